// File: doc/BRIEF.md
# LIN Break and Receive-Edge Status Unit

This block sits next to a UART-style receiver on a LIN bus. It watches the raw receive line through a synchroniser and measures how long the line stays dominant, counting in ticks of a 16x oversample strobe. When a dominant run grows past a programmable length, the block reports a break. That length is 10 bit times normally and 11 bit times in LIN mode, so that a zero character that a fast slave clock stretches to about 10.26 bit times is not mistaken for a break. The block also flags any active edge on the receive pin, with the polarity set by the receive-inversion control. It gates the receiver's framing-error report and keeps a parity-error flag.

Software reaches the block through a small register port with four addresses. Status 1 is at address 0 and holds the parity flag in bit 0. Status 2 is at address 1 and holds the break flag in bit 7 and the edge flag in bit 6. Address 2 is the receive data register, which returns the receiver's byte. Address 3 holds the interrupt enables. Each flag drives its own level interrupt, and that interrupt is gated by an enable bit.

Top module: `lin_rx_status`

## Requirements
- R1: After reset, all three flags, the interrupt enables and all interrupt outputs are 0. Status 2 reads 8'h00.
- R2: The line is dominant when it is low, or when it is high while receive inversion is set. With LIN mode (`brk_en_i`) clear, `brk_det_o` pulses once a dominant run reaches 160 oversample ticks (10 bit times). A run of 159 ticks produces no pulse.
- R3: With LIN mode set, the threshold is 176 ticks (11 bit times). A run of 175 ticks, and a 164-tick zero character, produce no pulse.
- R4: A break is reported at most once per dominant run, however long the run lasts. Detection re-arms only after the line returns to recessive.
- R5: The break flag (address 1, bit 7) sets on a detected break only while LIN mode is set. Writing 1 to bit 7 clears it.
- R6: The edge flag (address 1, bit 6) sets on a falling pin edge when inversion is 0, and on a rising pin edge when inversion is 1. The opposite edge does not set it. Writing 1 to bit 6 clears it, and writing 0 has no effect.
- R7: Bits 5..0 of status 2 and bits 7..1 of status 1 always read 0.
- R8: `fe_o` follows `fe_raw_i` while LIN mode is clear and is held at 0 while LIN mode is set.
- R9: The parity flag (address 0, bit 0) sets on an `rdrf_set_i` pulse when parity is enabled and `par_bit_i` differs from `par_exp_i`. It does not set when the bits match or when parity is disabled.
- R10: The parity flag clears on a read of address 2 that follows a read of address 0 made while the flag was set. A read of address 2 alone leaves the flag set.
- R11: When a flag's set event and its clear action fall in the same cycle, the set wins.
- R12: Address 3 bits 0, 1 and 2 enable the break, edge and parity interrupts, and the register reads back. Each interrupt output equals its flag ANDed with its enable.
- R13: Address 2 reads back `rx_byte_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Raw receive line (asynchronous) |
| os_tick_i | input | 1 | 16x oversample strobe, one cycle wide |
| brk_en_i | input | 1 | LIN mode: 11-bit break threshold, break flag enabled, framing errors suppressed |
| rx_inv_i | input | 1 | Receive inversion |
| par_en_i | input | 1 | Parity checking enable |
| rdrf_set_i | input | 1 | Receiver has completed a character (one-cycle pulse) |
| par_bit_i | input | 1 | Received parity bit |
| par_exp_i | input | 1 | Expected parity bit |
| fe_raw_i | input | 1 | Framing error from the receiver |
| rx_byte_i | input | 8 | Received byte |
| addr_i | input | 2 | Register address |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational from `addr_i`) |
| fe_o | output | 1 | Gated framing error |
| brk_det_o | output | 1 | Break detected pulse |
| brk_irq_o | output | 1 | Break interrupt |
| edge_irq_o | output | 1 | Receive-edge interrupt |
| par_irq_o | output | 1 | Parity interrupt |

## Verification
The assertions assume that `rdrf_set_i` and register strobes are single-cycle and that `addr_i` is stable while a strobe is high. They also assume reset is held long enough to flush the synchroniser. The bench changes every input on the falling clock edge and holds the receive line recessive through reset. It keeps the oversample strobe high every cycle during the break sweeps, so a dominant run measured in cycles equals its length in ticks. Strobes are raised for exactly one cycle from tasks.

// File: rtl/lin_rx_pkg.sv
// Shared definitions for the LIN receive status unit.
// Assumes a 2-bit register address space with four registers.
package lin_rx_pkg;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;
    localparam int BRK_POS  = 7;
    localparam int EDGE_POS = 6;
    localparam int PAR_POS  = 0;
    localparam int IE_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT1 = 2'd0,
        REG_STAT2 = 2'd1,
        REG_DATA  = 2'd2,
        REG_CTRL  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic par;
        logic edge_f;
        logic brk;
    } flag_set_t;
endpackage

// File: rtl/rx_edge_sync.sv
// Synchronises the raw receive line and detects the active edge.
// Produces a dominant-level indication with inversion applied.
// Assumes the line idles high at reset; SYNC_STAGES >= 2.
module rx_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    input  logic inv_i,
    output logic dom_o,
    output logic act_edge_o
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   line;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-2:0], rxd_i};
    end

    assign line = chain[SYNC_STAGES-1];

    // Remember the previous synchronised sample for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= line;
    end

    // Pick the edge direction selected by inversion; derive dominance.
    always_comb begin
        act_edge_o = inv_i ? (!prev && line) : (prev && !line);
        dom_o      = !(line ^ inv_i);
    end
endmodule

// File: rtl/brk_run_counter.sv
// Counts oversample ticks while the line is dominant and reports a break
// once the run reaches the selected threshold. One report per run.
// Assumes tick_i is a single-cycle strobe.
module brk_run_counter #(
    parameter int OS_RATE  = 16,
    parameter int STD_BITS = 10,
    parameter int LIN_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic dom_i,
    input  logic lin_mode_i,
    output logic hit_o
);
    localparam int STD_TICKS = OS_RATE * STD_BITS;
    localparam int LIN_TICKS = OS_RATE * LIN_BITS;
    localparam int MAX_TICKS = (LIN_TICKS > STD_TICKS) ? LIN_TICKS : STD_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] STD_LAST = CNT_W'(STD_TICKS - 1);
    localparam logic [CNT_W-1:0] LIN_LAST = CNT_W'(LIN_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_TICKS);

    logic [CNT_W-1:0] cnt;
    logic             fired;
    logic [CNT_W-1:0] last;

    // Select the final tick index for the active threshold.
    always_comb begin
        last  = lin_mode_i ? LIN_LAST : STD_LAST;
        hit_o = tick_i && dom_i && !fired && (cnt >= last);
    end

    // Track the dominant run length and the once-per-run latch.
    always_ff @(posedge clk) begin
        if (!rst_n || !dom_i) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (tick_i) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (hit_o)          fired <= 1'b1;
        end
    end
endmodule

// File: rtl/lin_stat_regs.sv
// Holds the status flags and interrupt enables and serves the register port.
// Sets win over clears. Parity clears on a status-1 read then a data read.
// Assumes strobes are single-cycle with a stable address.
module lin_stat_regs
    import lin_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  flag_set_t         set_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              brk_flag_o,
    output logic              edge_flag_o,
    output logic              par_flag_o,
    output logic [IE_W-1:0]   ie_o
);
    logic armed;
    logic w_stat2, w_ctrl, r_stat1, r_data;

    // Decode register accesses.
    always_comb begin
        w_stat2 = wr_en_i && (addr_i == REG_STAT2);
        w_ctrl  = wr_en_i && (addr_i == REG_CTRL);
        r_stat1 = rd_en_i && (addr_i == REG_STAT1);
        r_data  = rd_en_i && (addr_i == REG_DATA);
    end

    // Break and edge flags: set on event, write-1-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_flag_o  <= 1'b0;
            edge_flag_o <= 1'b0;
        end else begin
            if (set_i.brk)                       brk_flag_o <= 1'b1;
            else if (w_stat2 && wdata_i[BRK_POS]) brk_flag_o <= 1'b0;
            if (set_i.edge_f)                     edge_flag_o <= 1'b1;
            else if (w_stat2 && wdata_i[EDGE_POS]) edge_flag_o <= 1'b0;
        end
    end

    // Parity flag with its two-step read clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_flag_o <= 1'b0;
            armed      <= 1'b0;
        end else begin
            if (set_i.par)                 par_flag_o <= 1'b1;
            else if (r_data && armed)      par_flag_o <= 1'b0;
            if (r_data)                    armed <= 1'b0;
            else if (r_stat1 && par_flag_o) armed <= 1'b1;
        end
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_o <= '0;
        else if (w_ctrl) ie_o <= wdata_i[IE_W-1:0];
    end

    // Read data multiplexer.
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            REG_STAT1: rdata_o[PAR_POS] = par_flag_o;
            REG_STAT2: begin
                rdata_o[BRK_POS]  = brk_flag_o;
                rdata_o[EDGE_POS] = edge_flag_o;
            end
            REG_DATA:  rdata_o = rx_byte_i;
            REG_CTRL:  rdata_o[IE_W-1:0] = ie_o;
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/lin_rx_status.sv
// Top of the LIN break and receive-edge status unit.
// Combines the synchroniser, the break run counter and the status registers.
// Assumes os_tick_i is a 16x bit-rate strobe and rxd_i idles high.
module lin_rx_status
    import lin_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int STD_BITS    = 10,
    parameter int LIN_BITS    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd_i,
    input  logic        os_tick_i,
    input  logic        brk_en_i,
    input  logic        rx_inv_i,
    input  logic        par_en_i,
    input  logic        rdrf_set_i,
    input  logic        par_bit_i,
    input  logic        par_exp_i,
    input  logic        fe_raw_i,
    input  logic [7:0]  rx_byte_i,
    input  logic [1:0]  addr_i,
    input  logic        rd_en_i,
    input  logic        wr_en_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    output logic        fe_o,
    output logic        brk_det_o,
    output logic        brk_irq_o,
    output logic        edge_irq_o,
    output logic        par_irq_o
);
    logic            dom;
    logic            edge_act;
    logic            brk_hit;
    logic            brk_flag, edge_flag, par_flag;
    logic [IE_W-1:0] ie;
    flag_set_t       sets;

    rx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .inv_i(rx_inv_i),
        .dom_o(dom), .act_edge_o(edge_act)
    );

    brk_run_counter #(.OS_RATE(OS_RATE), .STD_BITS(STD_BITS), .LIN_BITS(LIN_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(os_tick_i), .dom_i(dom),
        .lin_mode_i(brk_en_i), .hit_o(brk_hit)
    );

    // Form the flag set events from detector outputs and receiver inputs.
    always_comb begin
        sets.brk    = brk_hit && brk_en_i;
        sets.edge_f = edge_act;
        sets.par    = rdrf_set_i && par_en_i && (par_bit_i != par_exp_i);
    end

    lin_stat_regs u_regs (
        .clk(clk), .rst_n(rst_n), .set_i(sets), .addr_i(addr_i),
        .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
        .rx_byte_i(rx_byte_i), .rdata_o(rdata_o),
        .brk_flag_o(brk_flag), .edge_flag_o(edge_flag),
        .par_flag_o(par_flag), .ie_o(ie)
    );

    // Drive detection, framing gate and level interrupts.
    always_comb begin
        brk_det_o  = brk_hit;
        fe_o       = fe_raw_i && !brk_en_i;
        brk_irq_o  = brk_flag  && ie[0];
        edge_irq_o = edge_flag && ie[1];
        par_irq_o  = par_flag  && ie[2];
    end
endmodule

// File: rtl/lin_rx_status_chk.sv
// Property checker for lin_rx_status, attached by bind.
// Assumes single-cycle strobes and a stable address during them.
module lin_rx_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       brk_en_i,
    input logic       fe_o,
    input logic       wr_en_i,
    input logic       rd_en_i,
    input logic [1:0] addr_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic       brk_det_o,
    input logic       brk_hit,
    input logic       edge_act,
    input logic       brk_flag,
    input logic       edge_flag,
    input logic       par_flag
);
    assert_brk_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_det_o |=> !brk_det_o);

    assert_brk_flag_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(brk_en_i));

    assert_edge_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_flag) |-> $past(edge_act));

    assert_stat2_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 2'd1) |-> (rdata_o[5:0] == 6'd0));

    assert_fe_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_en_i |-> !fe_o);

    assert_par_clear_by_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(par_flag) |-> $past(rd_en_i && addr_i == 2'd2));

    assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_hit && brk_en_i && wr_en_i && addr_i == 2'd1 && wdata_i[7]) |=> brk_flag);
endmodule

bind lin_rx_status lin_rx_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .brk_en_i(brk_en_i), .fe_o(fe_o),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .brk_det_o(brk_det_o), .brk_hit(brk_hit),
    .edge_act(edge_act), .brk_flag(brk_flag), .edge_flag(edge_flag),
    .par_flag(par_flag)
);

// File: tb/tb_lin_rx_status.sv
module tb_lin_rx_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1, tick = 1'b1, brk_en = 1'b0, inv = 1'b0, par_en = 1'b0;
    logic       rdrf = 1'b0, pbit = 1'b0, pexp = 1'b0, fe_raw = 1'b0;
    logic [7:0] rx_byte = 8'h5A;
    logic [1:0] addr = 2'd0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       fe, brk_det, brk_irq, edge_irq, par_irq;

    int checks = 0, fails = 0, pulses = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lin_rx_status dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .os_tick_i(tick), .brk_en_i(brk_en),
        .rx_inv_i(inv), .par_en_i(par_en), .rdrf_set_i(rdrf), .par_bit_i(pbit),
        .par_exp_i(pexp), .fe_raw_i(fe_raw), .rx_byte_i(rx_byte), .addr_i(addr),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
        .fe_o(fe), .brk_det_o(brk_det), .brk_irq_o(brk_irq),
        .edge_irq_o(edge_irq), .par_irq_o(par_irq)
    );

    always @(negedge clk) if (brk_det) pulses++;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic low_run(input int n);
        @(negedge clk); rxd = 1'b0;
        repeat (n) @(negedge clk);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd1, d); check("R1 stat2", d, 8'h00);
        rd(2'd0, d); check("R1 stat1", d, 8'h00);
        rd(2'd3, d); check("R1 ctrl", d, 8'h00);
        check("R1 irqs", {brk_irq, edge_irq, par_irq}, 0);

        // R2/R3 sweep of run lengths around both thresholds
        for (int m = 0; m < 2; m++) begin
            brk_en = m[0];
            for (int n = 150; n <= 180; n++) begin
                int thr;
                thr = m ? 176 : 160;
                pulses = 0;
                low_run(n);
                check(m ? "R3 lin threshold" : "R2 std threshold", pulses, (n >= thr) ? 1 : 0);
            end
        end
        // R3 stretched zero character, 164 ticks, in LIN mode
        brk_en = 1'b1; pulses = 0; low_run(164);
        check("R3 stretched zero char", pulses, 0);
        // R4 long run reports once, then re-arms
        pulses = 0; low_run(500);
        check("R4 once per run", pulses, 1);
        pulses = 0; low_run(200);
        check("R4 re-arm", pulses, 1);

        // R5 break flag set in LIN mode, W1C
        rd(2'd1, d); check("R5 flag set in lin mode", d[7], 1);
        wr(2'd1, 8'h80);
        rd(2'd1, d); check("R5 w1c", d[7], 0);
        brk_en = 1'b0; low_run(200);
        rd(2'd1, d); check("R5 no flag without enable", d[7], 0);

        // R6 edge flag polarity and clearing
        wr(2'd1, 8'hC0);
        rd(2'd1, d); check("R6 cleared", d[6], 0);
        @(negedge clk); rxd = 1'b0; repeat (5) @(negedge clk);
        rd(2'd1, d); check("R6 falling sets", d[6], 1);
        wr(2'd1, 8'h00);
        rd(2'd1, d); check("R6 write 0 no effect", d[6], 1);
        wr(2'd1, 8'h40);
        @(negedge clk); rxd = 1'b1; repeat (5) @(negedge clk);
        rd(2'd1, d); check("R6 rising ignored inv0", d[6], 0);
        inv = 1'b1;
        @(negedge clk); rxd = 1'b0; repeat (5) @(negedge clk);
        rd(2'd1, d); check("R6 falling ignored inv1", d[6], 0);
        @(negedge clk); rxd = 1'b1; repeat (5) @(negedge clk);
        rd(2'd1, d); check("R6 rising sets inv1", d[6], 1);
        // R7 reserved bits (flag bits masked off)
        check("R7 stat2 low bits", d[5:0], 0);
        inv = 1'b0;

        // R12 interrupt gating with edge flag set
        wr(2'd3, 8'h02);
        rd(2'd3, d); check("R12 ctrl readback", d, 8'h02);
        #1 check("R12 edge irq on", edge_irq, 1);
        wr(2'd3, 8'h05);
        #1 check("R12 edge irq off", edge_irq, 0);
        wr(2'd1, 8'h40);

        // R8 framing gate
        fe_raw = 1'b1; brk_en = 1'b0; #1 check("R8 fe passes", fe, 1);
        brk_en = 1'b1; #1 check("R8 fe blocked", fe, 0);
        fe_raw = 1'b0; brk_en = 1'b0;

        // R9 parity set conditions
        @(negedge clk); par_en = 1'b0; pbit = 1'b1; pexp = 1'b0; rdrf = 1'b1;
        @(negedge clk); rdrf = 1'b0;
        rd(2'd0, d); check("R9 disabled no set", d, 0);
        @(negedge clk); par_en = 1'b1; pbit = 1'b1; pexp = 1'b1; rdrf = 1'b1;
        @(negedge clk); rdrf = 1'b0;
        rd(2'd0, d); check("R9 match no set", d, 0);
        @(negedge clk); pexp = 1'b0; rdrf = 1'b1;
        @(negedge clk); rdrf = 1'b0;
        rd(2'd2, d); check("R13 data readback", d, 8'h5A);
        rd(2'd0, d); check("R9 mismatch sets", d, 8'h01);
        check("R12 par irq", par_irq, 1);
        // R10 clear sequence; earlier data read alone did not clear
        rd(2'd2, d);
        rd(2'd0, d); check("R10 cleared after sequence", d, 0);
        @(negedge clk); rdrf = 1'b1;
        @(negedge clk); rdrf = 1'b0;
        rd(2'd2, d);
        rd(2'd0, d); check("R10 data read alone keeps", d, 1);
        // R11 set wins over clear in the same cycle (stat1 read above armed it)
        @(negedge clk); addr = 2'd2; rd_en = 1'b1; rdrf = 1'b1;
        @(negedge clk); rd_en = 1'b0; rdrf = 1'b0;
        rd(2'd1, d);
        rd(2'd0, d); check("R11 set wins", d, 1);
        finish_run();
    end
endmodule